// File: doc/BRIEF.md
# 32-bit Arithmetic and Logic Unit with Function Select

This block is the combinational execute datapath of a small RISC core. Two 32-bit operands enter together with a 3-bit function code and a few mode controls. Every candidate result is formed in parallel: the adder/subtracter, a shared bitwise-logic slice, a barrel shifter and a signed comparator. The function code then picks one of them as the 32-bit result, all within the same cycle.

Around this block, instruction decode supplies the function code and mode bits. Decode also chooses between a register value and an immediate for the second operand. The comparator reuses the adder's difference and is gated by two enables, so equal, less-than and less-or-equal all share one datapath. Function code 111 forces the result to zero so that nothing is driven onto the result path.

Top module: `alu32`

## Requirements
- R1: With function code 000 and add control 1, the result is A+B modulo 2^32, for example 0x7FFFFFFF+1 = 0x80000000.
- R2: With function code 000 and add control 0, the result is A−B modulo 2^32, for example 0−1 = 0xFFFFFFFF.
- R3: Function codes 001, 010 and 011 give the bitwise AND, OR and XOR of A and B.
- R4: Function code 100 with the left control at 1 shifts A left by B[4:0] bits and fills with zeros. Bits B[31:5] have no effect.
- R5: Function code 100 with the left control at 0 and the arithmetic control at 0 shifts A right by B[4:0] bits with zero fill. A shift amount of 0 returns A.
- R6: On a right shift with the arithmetic control at 1, the vacated bits take A[31]. On a left shift the arithmetic control has no effect.
- R7: Function code 101 returns A unchanged.
- R8: Function code 110, with the add control at 0, returns 1 when (equal enable and A==B) or (less enable and A<B signed), and returns 0 otherwise. Both enables set gives less-or-equal. Neither enable set gives 0.
- R9: The signed less-than stays correct when A−B overflows. It is taken from the sign bits of A, B and A−B, so 0x80000000 < 1 is true and 0x7FFFFFFF < 0x80000000 is false.
- R10: Function code 111 drives the result to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A; also the shifted and passed value |
| b_i | input | 32 | Operand B; low 5 bits give the shift amount |
| func_i | input | 3 | Function code selecting the result |
| add_i | input | 1 | 1 = add, 0 = subtract (subtract for compares) |
| left_i | input | 1 | 1 = shift left, 0 = shift right |
| arith_i | input | 1 | 1 = sign fill on right shifts |
| eq_en_i | input | 1 | Compare yields 1 on equality |
| lt_en_i | input | 1 | Compare yields 1 on signed less-than |
| y_o | output | 32 | Selected result |

## Verification
The block holds no state, so any fault in a candidate path appears on y_o in the same cycle that its function code is selected. It stays hidden while another code is selected. The bench therefore selects each code with operands that expose that path's corner cases:
- carry wrap in the adder;
- sign fill and ignored upper amount bits in the shifter;
- subtraction overflow in the comparator;
- the idle code.

An error in a single shifter stage or comparator term shows only for the operand values that use it, which is why the bench chooses amounts and sign combinations that use each one.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int WIDTH = 32;
    localparam int SHW   = $clog2(WIDTH);

    typedef enum logic [2:0] {
        FN_ARITH = 3'b000,
        FN_AND   = 3'b001,
        FN_OR    = 3'b010,
        FN_XOR   = 3'b011,
        FN_SHIFT = 3'b100,
        FN_PASS  = 3'b101,
        FN_CMP   = 3'b110,
        FN_IDLE  = 3'b111
    } func_e;

    typedef struct packed {
        logic eq;
        logic lt;
    } cmp_flags_t;

    // Truth table per bit, indexed by {a,b}: bit3 = a1b1 ... bit0 = a0b0
    function automatic logic [3:0] logic_table(input func_e f);
        case (f)
            FN_AND:  logic_table = 4'b1000;
            FN_OR:   logic_table = 4'b1110;
            FN_XOR:  logic_table = 4'b0110;
            FN_PASS: logic_table = 4'b1100;
            default: logic_table = 4'b0000;
        endcase
    endfunction

    // Signed less-than from the three sign bits of a, b and a-b
    function automatic logic signed_lt(input logic a_msb, input logic b_msb,
                                       input logic s_msb);
        signed_lt = (a_msb & ~b_msb) | (~(a_msb ^ b_msb) & s_msb);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = WIDTH
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         add_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = add_i ? b_i : ~b_i;
        sum_o = a_i + b_eff + {{(W-1){1'b0}}, ~add_i};
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = WIDTH
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  func_e        func_i,
    output logic [W-1:0] y_o
);
    logic [3:0] table_q;

    always_comb table_q = logic_table(func_i);

    // One 4:1 selection per bit: operand bits address the truth table
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y_o[i] = table_q[{a_i[i], b_i[i]}];
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W  = WIDTH,
    parameter int SW = SHW
) (
    input  logic [W-1:0]  a_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          arith_i,
    output logic [W-1:0]  y_o
);
    logic [SW:0][W-1:0] lchain;
    logic [SW:0][W-1:0] rchain;
    logic               fill;

    assign fill      = arith_i & a_i[W-1];
    assign lchain[0] = a_i;
    assign rchain[0] = a_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign lchain[k+1] = amt_i[k] ? {lchain[k][W-1-D:0], {D{1'b0}}}
                                      : lchain[k];
        assign rchain[k+1] = amt_i[k] ? {{D{fill}}, rchain[k][W-1:D]}
                                      : rchain[k];
    end

    assign y_o = left_i ? lchain[SW] : rchain[SW];

    always_comb begin
        // R5
        if (amt_i == '0) begin
            zero_amt_chk: assert (y_o == a_i)
                else $error("shift by zero altered the operand");
        end
        // R6
        if (!left_i && arith_i && amt_i != '0) begin
            sign_fill_chk: assert (y_o[W-1] == a_i[W-1])
                else $error("arithmetic right shift lost the sign");
        end
    end
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp
    import alu_pkg::*;
#(
    parameter int W = WIDTH
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] diff_i,
    output cmp_flags_t   flags_o
);
    always_comb begin
        flags_o.eq = ~(|diff_i);
        flags_o.lt = signed_lt(a_i[W-1], b_i[W-1], diff_i[W-1]);
    end
endmodule

// File: rtl/alu32.sv
module alu32
    import alu_pkg::*;
(
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    input  logic [2:0]  func_i,
    input  logic        add_i,
    input  logic        left_i,
    input  logic        arith_i,
    input  logic        eq_en_i,
    input  logic        lt_en_i,
    output logic [31:0] y_o
);
    localparam int W = 32;

    func_e        fsel;
    logic [W-1:0] sum;
    logic [W-1:0] logic_y;
    logic [W-1:0] shift_y;
    cmp_flags_t   flags;
    logic         cmp_bit;

    assign fsel = func_e'(func_i);

    alu_addsub #(.W(W)) u_addsub (
        .a_i(a_i), .b_i(b_i), .add_i(add_i), .sum_o(sum)
    );

    alu_logic #(.W(W)) u_logic (
        .a_i(a_i), .b_i(b_i), .func_i(fsel), .y_o(logic_y)
    );

    alu_shift #(.W(W), .SW(SHW)) u_shift (
        .a_i(a_i), .amt_i(b_i[SHW-1:0]), .left_i(left_i),
        .arith_i(arith_i), .y_o(shift_y)
    );

    alu_cmp #(.W(W)) u_cmp (
        .a_i(a_i), .b_i(b_i), .diff_i(sum), .flags_o(flags)
    );

    assign cmp_bit = (eq_en_i & flags.eq) | (lt_en_i & flags.lt);

    always_comb begin
        unique case (fsel)
            FN_ARITH:                        y_o = sum;
            FN_AND, FN_OR, FN_XOR, FN_PASS:  y_o = logic_y;
            FN_SHIFT:                        y_o = shift_y;
            FN_CMP:                          y_o = {{(W-1){1'b0}}, cmp_bit};
            default:                         y_o = '0;
        endcase
    end

    always_comb begin
        // R10
        if (fsel == FN_IDLE) begin
            idle_zero_chk: assert (y_o == '0)
                else $error("idle code drove a value");
        end
        // R7
        if (fsel == FN_PASS) begin
            pass_a_chk: assert (y_o == a_i)
                else $error("pass mode altered A");
        end
        // R8
        if (fsel == FN_CMP) begin
            cmp_width_chk: assert (y_o[W-1:1] == '0)
                else $error("compare result wider than one bit");
        end
        // R9
        if (!add_i && flags.eq) begin
            eq_excl_lt_chk: assert (!flags.lt)
                else $error("equal and less-than both set");
        end
    end
endmodule

// File: tb/sim_alu32.sv
module sim_alu32;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [2:0]  func;
    logic        add, left, arith, eq_en, lt_en;
    logic [31:0] y;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    alu32 u0 (
        .a_i(a), .b_i(b), .func_i(func), .add_i(add), .left_i(left),
        .arith_i(arith), .eq_en_i(eq_en), .lt_en_i(lt_en), .y_o(y)
    );

    task automatic apply(input logic [31:0] ta, input logic [31:0] tb_,
                         input logic [2:0] tf, input logic tadd,
                         input logic tl, input logic tar,
                         input logic te, input logic tlt);
        @(posedge clk);
        a = ta; b = tb_; func = tf; add = tadd; left = tl; arith = tar;
        eq_en = te; lt_en = tlt;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] exp);
        checks++;
        if (y !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, y, exp);
        end
    endtask

    task automatic t_reset_state();
        apply(0, 0, 3'b000, 1, 0, 0, 0, 0);
        chk("R1 zero inputs", 32'h0);
    endtask

    task automatic t_add();
        apply(32'h1234_5678, 32'h1111_1111, 3'b000, 1, 0, 0, 0, 0);
        chk("R1 add", 32'h2345_6789);
        apply(32'h7FFF_FFFF, 32'h1, 3'b000, 1, 0, 0, 0, 0);
        chk("R1 wrap", 32'h8000_0000);
        apply(32'hFFFF_FFFF, 32'h2, 3'b000, 1, 0, 0, 0, 0);
        chk("R1 carry drop", 32'h1);
    endtask

    task automatic t_sub();
        apply(32'h0, 32'h1, 3'b000, 0, 0, 0, 0, 0);
        chk("R2 sub borrow", 32'hFFFF_FFFF);
        apply(32'h9, 32'h4, 3'b000, 0, 0, 0, 0, 0);
        chk("R2 sub", 32'h5);
    endtask

    task automatic t_logic();
        logic [31:0] pa = 32'hF0F0_AA55, pb = 32'hFF00_5A5A;
        apply(pa, pb, 3'b001, 1, 0, 0, 0, 0); chk("R3 and", pa & pb);
        apply(pa, pb, 3'b010, 1, 0, 0, 0, 0); chk("R3 or",  pa | pb);
        apply(pa, pb, 3'b011, 1, 0, 0, 0, 0); chk("R3 xor", pa ^ pb);
    endtask

    task automatic t_shift();
        logic [31:0] v = 32'h8000_000A;
        for (int s = 0; s < 32; s += 7) begin
            apply(v, 32'hFFFF_FFE0 | s, 3'b100, 1, 1, 1, 0, 0);
            chk("R4 R6 left, upper B and arith ignored", v << s);
            apply(v, s, 3'b100, 1, 0, 0, 0, 0);
            chk("R5 logical right", v >> s);
            apply(v, s, 3'b100, 1, 0, 1, 0, 0);
            chk("R6 arithmetic right", 32'($signed(v) >>> s));
        end
        apply(32'h4000_0001, 31, 3'b100, 1, 0, 1, 0, 0);
        chk("R6 positive arith right", 32'h0);
        apply(32'h1, 31, 3'b100, 1, 1, 0, 0, 0);
        chk("R4 max left", 32'h8000_0000);
    endtask

    task automatic t_pass();
        apply(32'hDEAD_BEEF, 32'h1234_5678, 3'b101, 1, 1, 1, 1, 1);
        chk("R7 pass", 32'hDEAD_BEEF);
    endtask

    task automatic t_cmp();
        logic [31:0] pa [4] = '{32'h5, 32'h5, 32'hFFFF_FFFE, 32'h8000_0000};
        logic [31:0] pb [4] = '{32'h5, 32'h3, 32'h1,         32'h1};
        for (int i = 0; i < 4; i++) begin
            bit e = (pa[i] == pb[i]);
            bit l = ($signed(pa[i]) < $signed(pb[i]));
            apply(pa[i], pb[i], 3'b110, 0, 0, 0, 1, 0);
            chk("R8 eq", {31'b0, e});
            apply(pa[i], pb[i], 3'b110, 0, 0, 0, 0, 1);
            chk("R8 lt", {31'b0, l});
            apply(pa[i], pb[i], 3'b110, 0, 0, 0, 1, 1);
            chk("R8 le", {31'b0, e | l});
            apply(pa[i], pb[i], 3'b110, 0, 0, 0, 0, 0);
            chk("R8 none", 32'h0);
        end
    endtask

    task automatic t_overflow_cmp();
        apply(32'h8000_0000, 32'h1, 3'b110, 0, 0, 0, 0, 1);
        chk("R9 min < 1", 32'h1);
        apply(32'h7FFF_FFFF, 32'h8000_0000, 3'b110, 0, 0, 0, 0, 1);
        chk("R9 max not < min", 32'h0);
        apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b110, 0, 0, 0, 1, 1);
        chk("R9 min <= max", 32'h1);
    endtask

    task automatic t_idle();
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111, 1, 1, 1, 1, 1);
        chk("R10 idle", 32'h0);
    endtask

    initial begin
        a = 0; b = 0; func = 0; add = 1; left = 0; arith = 0;
        eq_en = 0; lt_en = 0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_pass();
        t_cmp();
        t_overflow_cmp();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule